// File: doc/BRIEF.md
# Reverse Cumulative Histogram Reducer

This block is the reduce step for one binned histogram. A histogram of `NUM_BINS` bins (256 by default), labelled with a feature index, is streamed in one bin per accepted beat, starting at bin 0. The bins are held in a local buffer. Once the last bin is stored, the block walks the buffer from the top bin down to bin 0. It keeps a running sum, so each emitted value is the suffix sum of the histogram: the total of that bin and every bin above it.

Each result leaves on a valid/ready stream. Every beat carries the bin index, the suffix-sum value and the feature index that came in with the histogram. Values are unsigned 32-bit fixed point, and the running sum clips at the largest 32-bit value instead of wrapping. The block holds one histogram at a time. Loading the next histogram opens only when the result for bin 0 has been taken.

Top module: `histIntegrator`

## Requirements
- R1: After reset, `inReady` is 1 and `outValid` is 0.
- R2: Input bins are stored in ascending index order, one per cycle with `inValid` and `inReady` both high. Idle cycles between beats are allowed. The beat after bin `NUM_BINS-1` is accepted has `inReady` low and `outValid` high.
- R3: Outputs appear in descending index order. The first output has `outIdx = NUM_BINS-1`, and each accepted output (`outValid` and `outReady` high) moves `outIdx` down by one, ending at 0.
- R4: `outData` at index i equals the sum of input bins i through `NUM_BINS-1`. The sum above the top bin counts as zero, so the value at the top index is the top input bin itself.
- R5: Once the true suffix sum exceeds 2^32-1, `outData` reads 32'hFFFFFFFF, and it stays there for all lower indices.
- R6: `outKey` equals the `inKey` presented with bin 0. Key values presented with bins 1 and above are ignored.
- R7: While `outValid` is high and `outReady` is low, `outIdx`, `outData` and `outKey` hold their values.
- R8: While results are being emitted, `inReady` is 0. `inValid` and its data have no effect on the results or on the next histogram.
- R9: The cycle after the bin-0 output is accepted, `inReady` is 1 and `outValid` is 0. The next histogram starts from a zero running sum.
- R10: `inReady` and `outValid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input bin present |
| inReady | output | 1 | Block can take an input bin |
| inKey | input | KEY_W | Feature index, sampled with bin 0 |
| inBin | input | DATA_W | Histogram bin count |
| outValid | output | 1 | Output result present |
| outReady | input | 1 | Consumer takes the result |
| outKey | output | KEY_W | Feature index of the histogram |
| outIdx | output | IDX_W | Bin index of the result |
| outData | output | DATA_W | Suffix sum at `outIdx`, saturating |

## Verification
The first result is due one clock edge after the last input bin is accepted. Each later result is due one edge after the previous result is accepted, and `inReady` returns one edge after bin 0 leaves. The bench drives inputs and samples outputs at the falling edge, between these rising edges. Because of that, every comparison sees the value produced by the most recent rising edge. Expected suffix sums are computed in the bench with 64-bit arithmetic and clipped to 32 bits. They are compared at every accepted result, including during stalls and while junk is driven on the input side.

// File: rtl/histIntPkg.sv
package histIntPkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic wrEn;     // store the current input bin
    logic keyCap;   // capture the feature index
    logic accStep;  // fold the emitted value into the running sum
    logic accClr;   // clear the running sum after bin 0
  } dpStrobe_t;
endpackage

// File: rtl/histIntCtrl.sv
module histIntCtrl
  import histIntPkg::*;
#(
  parameter int NUM_BINS = 256,
  localparam int IDX_W = $clog2(NUM_BINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output dpStrobe_t        strb,
  output logic [IDX_W-1:0] wrAddr,
  output logic [IDX_W-1:0] rdAddr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BINS - 1);

  typedef enum logic {LOAD, SCAN} state_t;
  state_t state;

  logic inFire, outFire;

  assign inReady  = (state == LOAD);
  assign outValid = (state == SCAN);
  assign inFire   = inValid && inReady;
  assign outFire  = outValid && outReady;

  always_comb begin
    strb.wrEn    = inFire;
    strb.keyCap  = inFire && (wrAddr == '0);
    strb.accStep = outFire && (rdAddr != '0);
    strb.accClr  = outFire && (rdAddr == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= LOAD;
      wrAddr <= '0;
      rdAddr <= LAST;
    end else begin
      case (state)
        LOAD: if (inFire) begin
          if (wrAddr == LAST) begin
            state  <= SCAN;
            wrAddr <= '0;
          end else begin
            wrAddr <= wrAddr + 1'b1;
          end
        end
        SCAN: if (outFire) begin
          if (rdAddr == '0) begin
            state  <= LOAD;
            rdAddr <= LAST;
          end else begin
            rdAddr <= rdAddr - 1'b1;
          end
        end
        default: state <= LOAD;
      endcase
    end
  end

  // R10
  handshake_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  // R3
  idx_descend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outFire && rdAddr != '0) |=> (outValid && rdAddr == $past(rdAddr) - 1'b1));

  // R3
  first_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (rdAddr == LAST));

  // R2
  load_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inFire && wrAddr == LAST) |=> (outValid && !inReady));
endmodule

// File: rtl/histIntData.sv
module histIntData
  import histIntPkg::*;
#(
  parameter int NUM_BINS = 256,
  parameter int DATA_W   = 32,
  parameter int KEY_W    = 16,
  localparam int IDX_W = $clog2(NUM_BINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [IDX_W-1:0]  rdAddr,
  input  logic [KEY_W-1:0]  inKey,
  input  logic [DATA_W-1:0] inBin,
  output logic [KEY_W-1:0]  outKey,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] binMem [NUM_BINS];
  logic [DATA_W-1:0] acc;     // holds integral(i+1)
  logic [DATA_W:0]   sumWide;

  always_ff @(posedge clk) begin
    if (strb.wrEn) binMem[wrAddr] <= inBin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outKey <= '0;
    else if (strb.keyCap) outKey <= inKey;
  end

  assign sumWide = {1'b0, acc} + {1'b0, binMem[rdAddr]};
  assign outData = sumWide[DATA_W] ? {DATA_W{1'b1}} : sumWide[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)             acc <= '0;
    else if (strb.accClr)  acc <= '0;
    else if (strb.accStep) acc <= outData;
  end

  // R5
  acc_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accStep |=> (acc >= $past(acc)));

  // R9
  acc_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.keyCap |-> (acc == '0));
endmodule

// File: rtl/histIntegrator.sv
module histIntegrator
  import histIntPkg::*;
#(
  parameter int NUM_BINS = 256,
  parameter int DATA_W   = 32,
  parameter int KEY_W    = 16,
  localparam int IDX_W = $clog2(NUM_BINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [KEY_W-1:0]  inKey,
  input  logic [DATA_W-1:0] inBin,
  output logic              outValid,
  input  logic              outReady,
  output logic [KEY_W-1:0]  outKey,
  output logic [IDX_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outData
);
  dpStrobe_t        strb;
  logic [IDX_W-1:0] wrAddr;

  histIntCtrl #(.NUM_BINS(NUM_BINS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(outIdx)
  );

  histIntData #(.NUM_BINS(NUM_BINS), .DATA_W(DATA_W), .KEY_W(KEY_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(outIdx),
    .inKey(inKey), .inBin(inBin),
    .outKey(outKey), .outData(outData)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outIdx) && $stable(outData) && $stable(outKey)));

  // R9
  reopen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outIdx == '0) |=> (inReady && !outValid));
endmodule

// File: tb/sim_histIntegrator.sv
module sim_histIntegrator;
  localparam int NB = 256;
  localparam int DW = 32;
  localparam int KW = 16;
  localparam int IW = $clog2(NB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [KW-1:0] inKey = '0;
  logic [DW-1:0] inBin = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [KW-1:0] outKey;
  logic [IW-1:0] outIdx;
  logic [DW-1:0] outData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] hist [NB];
  logic [DW-1:0] expv [NB];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  histIntegrator #(.NUM_BINS(NB), .DATA_W(DW), .KEY_W(KW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inKey(inKey), .inBin(inBin), .outValid(outValid), .outReady(outReady),
    .outKey(outKey), .outIdx(outIdx), .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic makeHist(input int mode);
    for (int i = 0; i < NB; i++) begin
      case (mode)
        0: hist[i] = '0;
        1: hist[i] = DW'(i);
        2: hist[i] = nextRand() >> 12;
        3: hist[i] = (i == 0) ? 32'd5 : 32'd0;
        4: hist[i] = (i == NB-1) ? 32'd7 : 32'd0;
        5: hist[i] = 32'h2000_0000;
        default: hist[i] = 32'hFFFF_FFFF;
      endcase
    end
    begin
      longint run = 0;
      for (int i = NB-1; i >= 0; i--) begin
        run = run + longint'(hist[i]);
        if (run > 64'hFFFF_FFFF) run = 64'hFFFF_FFFF;
        expv[i] = run[31:0];
      end
    end
  endtask

  // load with occasional idle beats; keys after bin 0 differ (R6)
  task automatic loadHist(input logic [KW-1:0] key, input int gapMod);
    int i = 0;
    while (i < NB) begin
      @(negedge clk);
      if (gapMod != 0 && (cycles % gapMod) == 0) begin
        inValid = 1'b0;
        inBin = 32'hDEAD_BEEF;
      end else begin
        chk(inReady == 1'b1, "R2 inReady during load", inReady, 1);
        inValid = 1'b1;
        inBin = hist[i];
        inKey = (i == 0) ? key : key + KW'(i) + 16'h0100;
        i++;
      end
      @(posedge clk);
    end
  endtask

  task automatic drainHist(input logic [KW-1:0] key, input int stallMod);
    int expIdx = NB-1;
    bit stalled = 1'b0;
    logic [IW-1:0] hIdx;
    logic [DW-1:0] hData;
    logic [KW-1:0] hKey;
    while (expIdx >= 0) begin
      @(negedge clk);
      // junk on the input side while emitting (R8)
      inValid = 1'b1;
      inBin = nextRand();
      inKey = 16'hBAD0;
      chk(outValid == 1'b1, "R2 outValid after load", outValid, 1);
      chk(inReady == 1'b0, "R10 inReady low while emitting", inReady, 0);
      if (stalled) begin
        chk(outIdx == hIdx && outData == hData && outKey == hKey,
            "R7 hold under stall", {outIdx, outData}, {hIdx, hData});
      end
      chk(outIdx == IW'(expIdx), "R3 output index order", outIdx, expIdx);
      chk(outData == expv[expIdx], "R4 R5 suffix sum", outData, expv[expIdx]);
      chk(outKey == key, "R6 output key", outKey, key);
      if (stallMod != 0 && (cycles % stallMod) == 1) begin
        outReady = 1'b0;
        stalled = 1'b1;
        hIdx = outIdx; hData = outData; hKey = outKey;
      end else begin
        outReady = 1'b1;
        stalled = 1'b0;
        expIdx--;
      end
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    outReady = 1'b0;
    chk(inReady == 1'b1, "R9 inReady after bin 0", inReady, 1);
    chk(outValid == 1'b0, "R9 outValid after bin 0", outValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(inReady == 1'b1, "R1 reset inReady", inReady, 1);
    chk(outValid == 1'b0, "R1 reset outValid", outValid, 0);
    rstN = 1'b1;
    for (int m = 0; m < 8; m++) begin
      makeHist(m % 7);
      loadHist(KW'(16'h0040 + m), (m % 2 == 1) ? 5 : 0);
      drainHist(KW'(16'h0040 + m), (m % 3 == 2) ? 3 : 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule